// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers 128 level-sensitive interrupt lines into one interrupt request for a processor. Every line can be disabled by a mask bit and can also be raised by software through a software-pending bit. Both kinds of bit are arranged in four 32-bit banks. Each bank has its own write-one-to-set and write-one-to-clear addresses, so software can change a single line without a read-modify-write.

When at least one enabled line is pending, the controller selects the lowest-numbered one. It latches that number and raises the processor request. Software reads the active register to learn the number, services the source and then writes the acknowledge bit, which lets the controller select again. If the latched source has already dropped by the time it is read, the read returns a spurious flag in the upper bits. A soft-reset command returns the block to its reset state, and a status bit reports when that reset has finished.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every software-pending bit is 0, the threshold reads 0xFF, status bit 0 reads 1 and `irq_out` is low.
- R2: Source n belongs to bank n>>5, bit n&31. Bank b's mask-clear address is 0x88+0x20·b and its mask-set address is 0x8C+0x20·b. A 1 in a written bit clears or sets that mask bit and a 0 leaves it alone. A read of either address returns the bank's mask.
- R3: Bank b's software-set address is 0x90+0x20·b and its software-clear address is 0x94+0x20·b. They follow the same write-one rule, and a read of either returns the bank's software-pending bits.
- R4: A source is pending when its mask bit is 0 and either its input or its software bit is 1. A masked source never raises `irq_out`.
- R5: With no winner held, the lowest-numbered pending source is latched and `irq_out` rises one clock after the source becomes pending. A read of 0x40 returns that number in bits 6:0.
- R6: A held winner, and `irq_out`, stay unchanged until an acknowledge, even when a lower-numbered source becomes pending.
- R7: A read of 0x40 while the held source is no longer pending returns all ones in bits 31:7, with the held number in bits 6:0.
- R8: Writing 1 to bit 0 of 0x48 acknowledges. On the same clock the lowest pending source is latched, so `irq_out` stays high when anything is still pending and drops otherwise.
- R9: Writing 1 to bit 1 of 0x10 starts a soft reset. Status bit 0 at 0x14 reads 0 during it, and after RST_CYCLES clocks it reads 1 again with all state as in R1.
- R10: The threshold register at 0x68 holds 8 bits and reads back. All sources share the top priority, so a value of 0 blocks new winners and any other value, including the reset value 0xFF, passes them.
- R11: A read of 0x00 returns the major version in bits 7:4 and the minor version in bits 3:0, and zero above them. The defaults give 0x50.
- R12: A read of an unmapped offset such as 0x20 returns 0, and a write to one changes nothing.
- R13: Read data appears on `bus_rdata` on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 128 | Level interrupt inputs, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A held winner that is corrupted or lost shows up in the first read of the active register, and `irq_out` drops or stays high on the clock after an acknowledge that should have done the opposite. A mask or software-pending bit left in the wrong state shows in the very next read of either alias of its bank. If that bit is unmasked, it also shows within two clocks as an unexpected request or a missing one. A soft-reset counter that stalls, or that ends too early, shows in the status bit within RST_CYCLES plus a few clocks of the command.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int unsigned SRC_N      = 128;
    localparam int unsigned BANK_W     = 32;
    localparam int unsigned BANK_N     = SRC_N / BANK_W;
    localparam int unsigned ID_W       = $clog2(SRC_N);
    localparam int unsigned BK_IDX_W   = $clog2(BANK_N);
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned FLAG_W     = DATA_W - ID_W;
    localparam int unsigned LEVEL_W    = 8;

    // register offsets (software visible)
    localparam logic [ADDR_W-1:0] A_VERSION   = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG    = 12'h010;
    localparam logic [ADDR_W-1:0] A_SYSSTAT   = 12'h014;
    localparam logic [ADDR_W-1:0] A_ACTIVE    = 12'h040;
    localparam logic [ADDR_W-1:0] A_ACK       = 12'h048;
    localparam logic [ADDR_W-1:0] A_LEVEL     = 12'h068;
    localparam logic [ADDR_W-1:0] A_BANK_BASE = 12'h088;
    localparam int unsigned       BANK_SHIFT  = 5;
    localparam int unsigned       BANK_SPAN   = BANK_N << BANK_SHIFT;

    localparam int unsigned ACK_BIT  = 0;
    localparam int unsigned SRST_BIT = 1;

    localparam logic [LEVEL_W-1:0] LEVEL_OPEN = '1;

    typedef enum logic [3:0] {
        KIND_NONE,
        KIND_VER,
        KIND_CFG,
        KIND_STAT,
        KIND_ACTIVE,
        KIND_ACK,
        KIND_LEVEL,
        KIND_BANK
    } reg_kind_e;

    // position inside a bank window: order is decoded by software
    typedef enum logic [1:0] {
        SLOT_MCLR = 2'd0,
        SLOT_MSET = 2'd1,
        SLOT_SSET = 2'd2,
        SLOT_SCLR = 2'd3
    } slot_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [BK_IDX_W-1:0]   bank;
        slot_e                 slot;
    } reg_sel_t;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } winner_t;

    function automatic logic [DATA_W-1:0] active_word(input logic [ID_W-1:0] id,
                                                      input logic live);
        return {{FLAG_W{~live}}, id};
    endfunction

endpackage

// File: rtl/irqv_decode.sv
module irqv_decode
    import irqv_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    logic [ADDR_W-1:0] off;
    logic              in_bank;

    always_comb begin
        off     = addr - A_BANK_BASE;
        in_bank = (addr >= A_BANK_BASE) && (32'(off) < BANK_SPAN)
                  && (off[4] == 1'b0) && (off[1:0] == 2'b00);
    end

    always_comb begin
        sel.kind = KIND_NONE;
        sel.bank = '0;
        sel.slot = SLOT_MCLR;
        case (addr)
            A_VERSION: sel.kind = KIND_VER;
            A_SYSCFG:  sel.kind = KIND_CFG;
            A_SYSSTAT: sel.kind = KIND_STAT;
            A_ACTIVE:  sel.kind = KIND_ACTIVE;
            A_ACK:     sel.kind = KIND_ACK;
            A_LEVEL:   sel.kind = KIND_LEVEL;
            default: begin
                if (in_bank) begin
                    sel.kind = KIND_BANK;
                    sel.bank = off[BANK_SHIFT +: BK_IDX_W];
                    sel.slot = slot_e'(off[3:2]);
                end
            end
        endcase
    end

endmodule

// File: rtl/irqv_bank_regs.sv
module irqv_bank_regs
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              clr_state,
    input  logic              wr_en,
    input  reg_sel_t          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [SRC_N-1:0]  mask_o,
    output logic [SRC_N-1:0]  swp_o
);

    for (genvar b = 0; b < BANK_N; b++) begin : g_bank
        logic              hit;
        logic [BANK_W-1:0] m_set, m_clr, s_set, s_clr;
        logic [BANK_W-1:0] m_q, s_q;

        always_comb begin
            hit   = wr_en && (sel.kind == KIND_BANK) && (sel.bank == BK_IDX_W'(b));
            m_set = (hit && sel.slot == SLOT_MSET) ? wdata[BANK_W-1:0] : '0;
            m_clr = (hit && sel.slot == SLOT_MCLR) ? wdata[BANK_W-1:0] : '0;
            s_set = (hit && sel.slot == SLOT_SSET) ? wdata[BANK_W-1:0] : '0;
            s_clr = (hit && sel.slot == SLOT_SCLR) ? wdata[BANK_W-1:0] : '0;
        end

        always_ff @(posedge clk) begin
            if (clr_state) begin
                m_q <= '1;
                s_q <= '0;
            end else begin
                m_q <= (m_q | m_set) & ~m_clr;
                s_q <= (s_q | s_set) & ~s_clr;
            end
        end

        assign mask_o[b*BANK_W +: BANK_W] = m_q;
        assign swp_o[b*BANK_W +: BANK_W]  = s_q;
    end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             clr_state,
    input  logic [SRC_N-1:0] req,
    input  logic             level_ok,
    input  logic             ack,
    output winner_t          win
);

    winner_t cand;
    winner_t win_q;
    logic    grant;

    // lowest index wins: scan downward so the last hit is the smallest
    function automatic winner_t pick(input logic [SRC_N-1:0] r);
        winner_t w;
        w = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (r[i]) begin
                w.vld = 1'b1;
                w.id  = ID_W'(i);
            end
        end
        return w;
    endfunction

    always_comb begin
        cand  = pick(req);
        grant = cand.vld && level_ok;
    end

    always_ff @(posedge clk) begin
        if (clr_state) begin
            win_q <= '0;
        end else if (!win_q.vld || ack) begin
            win_q <= grant ? cand : '0;
        end
    end

    assign win = win_q;

endmodule

// File: rtl/irqv_reset_seq.sv
module irqv_reset_seq #(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q <= CNT_W'(RST_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4,
    parameter logic [3:0]  VER_MAJ    = 4'd5,
    parameter logic [3:0]  VER_MIN    = 4'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_lvl,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    reg_sel_t            sel;
    logic                rst_busy;
    logic                clr_state;
    logic                wr_ok;
    logic                ack;
    logic                srst_go;
    logic [SRC_N-1:0]    mask_vec;
    logic [SRC_N-1:0]    swp_vec;
    logic [SRC_N-1:0]    pending;
    logic [LEVEL_W-1:0]  level_q;
    logic                level_ok;
    winner_t             win;
    logic                win_vld;
    logic [ID_W-1:0]     win_id;
    logic                live;
    logic [DATA_W-1:0]   rd_val;
    logic [BANK_W-1:0]   bank_mask;
    logic [BANK_W-1:0]   bank_swp;

    irqv_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    irqv_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst   (rst),
        .start (srst_go),
        .busy  (rst_busy)
    );

    always_comb begin
        clr_state = rst || rst_busy;
        wr_ok     = bus_wr && !rst_busy;
        ack       = wr_ok && (sel.kind == KIND_ACK)  && bus_wdata[ACK_BIT];
        srst_go   = wr_ok && (sel.kind == KIND_CFG)  && bus_wdata[SRST_BIT];
    end

    irqv_bank_regs u_banks (
        .clk       (clk),
        .clr_state (clr_state),
        .wr_en     (wr_ok),
        .sel       (sel),
        .wdata     (bus_wdata),
        .mask_o    (mask_vec),
        .swp_o     (swp_vec)
    );

    // priority threshold: every source sits at the top level 0,
    // so only a threshold of 0 stops new selections
    always_ff @(posedge clk) begin
        if (clr_state) begin
            level_q <= LEVEL_OPEN;
        end else if (wr_ok && sel.kind == KIND_LEVEL) begin
            level_q <= bus_wdata[LEVEL_W-1:0];
        end
    end

    always_comb begin
        pending  = (src_lvl | swp_vec) & ~mask_vec;
        level_ok = (level_q != '0);
    end

    irqv_arbiter u_arb (
        .clk       (clk),
        .clr_state (clr_state),
        .req       (pending),
        .level_ok  (level_ok),
        .ack       (ack),
        .win       (win)
    );

    always_comb begin
        win_vld   = win.vld;
        win_id    = win.id;
        live      = win.vld && pending[win.id];
        bank_mask = mask_vec[sel.bank*BANK_W +: BANK_W];
        bank_swp  = swp_vec[sel.bank*BANK_W +: BANK_W];
    end

    always_comb begin
        rd_val = '0;
        case (sel.kind)
            KIND_VER:    rd_val = {{(DATA_W-8){1'b0}}, VER_MAJ, VER_MIN};
            KIND_STAT:   rd_val = {{(DATA_W-1){1'b0}}, ~rst_busy};
            KIND_ACTIVE: rd_val = active_word(win_id, live);
            KIND_LEVEL:  rd_val = {{(DATA_W-LEVEL_W){1'b0}}, level_q};
            KIND_BANK: begin
                if (sel.slot == SLOT_MCLR || sel.slot == SLOT_MSET) begin
                    rd_val = bank_mask;
                end else begin
                    rd_val = bank_swp;
                end
            end
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    assign irq_out = win_vld;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irqv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_wdata_lo,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic              win_vld,
    input logic [ID_W-1:0]   win_id,
    input logic              rst_busy
);

    logic ack_w;
    logic srst_w;

    always_comb begin
        ack_w  = bus_wr && (bus_addr == A_ACK)    && bus_wdata_lo[ACK_BIT];
        srst_w = bus_wr && (bus_addr == A_SYSCFG) && bus_wdata_lo[SRST_BIT];
    end

    // R1: reset leaves no request
    a_r1_irq_low_after_reset: assert property (@(posedge clk)
        rst |=> !irq_out);

    // R6: held winner and request stay put until acknowledge
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !ack_w && !srst_w && !rst_busy) |=> (irq_out && $stable(win_id)));

    // R5: active read reports the held number
    a_r5_active_id: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_ACTIVE && win_vld) |=> (bus_rdata[ID_W-1:0] == $past(win_id)));

    // R9: soft reset command enters the busy phase and drops the request
    a_r9_busy_after_srst: assert property (@(posedge clk) disable iff (rst)
        (srst_w && !rst_busy) |=> rst_busy);

    // R9: status read reflects the busy phase
    a_r9_status_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_SYSSTAT) |=> (bus_rdata == {31'b0, !$past(rst_busy)}));

    // R11: version word has nothing above bit 7
    a_r11_version_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_VERSION) |=> (bus_rdata[DATA_W-1:8] == '0));

    // R12: an unmapped offset reads zero
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 12'h020) |=> (bus_rdata == '0));

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata_lo (bus_wdata[1:0]),
    .bus_rdata    (bus_rdata),
    .irq_out      (irq_out),
    .win_vld      (win_vld),
    .win_id       (win_id),
    .rst_busy     (rst_busy)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] src_lvl;
    logic         bus_wr;
    logic         bus_rd;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         irq_out;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_due = 1'b0;

    always #2 clk = ~clk;

    irq_vec_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .src_lvl   (src_lvl),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // monitor: a read sampled at a rising edge is compared at the next falling edge (R13)
    always @(posedge clk) mon_due <= bus_rd;

    always @(negedge clk) begin
        if (mon_due) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_irq(input logic e, input string t);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_lvl = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_irq(1'b0, "R1 irq after reset");
        for (int b = 0; b < 4; b++) rd(12'(12'h08C + b*12'h020), 32'hFFFF_FFFF, "R1 mask bank");
        rd(12'h090, 32'h0, "R1 swp bank0");
        rd(12'h068, 32'h0000_00FF, "R1 threshold");
        rd(12'h014, 32'h1, "R1 status");
        rd(12'h000, 32'h0000_0050, "R11 version");
        rd(12'h020, 32'h0, "R12 unmapped read");

        // R4 masked source ignored
        src_lvl[40] = 1'b1;
        idle(3);
        check_irq(1'b0, "R4 masked source");

        // R2 write-one mask clear/set, bank1 bits 8,9 = sources 40,41
        wr(12'h0A8, 32'h0000_0300);
        rd(12'h0A8, 32'hFFFF_FCFF, "R2 mask clear");
        wr(12'h0AC, 32'h0);
        rd(12'h0AC, 32'hFFFF_FCFF, "R2 zero write no effect");
        check_irq(1'b1, "R4 unmasked source raises irq");
        rd(12'h040, 32'd40, "R5 active id 40");

        // R6 lower-numbered arrival does not displace held winner
        wr(12'h088, 32'h0000_0020);
        wr(12'h090, 32'h0000_0020);
        rd(12'h090, 32'h0000_0020, "R3 swp set");
        idle(2);
        check_irq(1'b1, "R6 irq held");
        rd(12'h040, 32'd40, "R6 held winner unchanged");

        // R8 acknowledge reselects lowest
        wr(12'h048, 32'h1);
        check_irq(1'b1, "R8 irq stays high after ack");
        rd(12'h040, 32'd5, "R8 new winner 5");

        // R7 spurious when held source drops
        wr(12'h094, 32'h0000_0020);
        rd(12'h094, 32'h0, "R3 swp clear");
        rd(12'h040, 32'hFFFF_FF85, "R7 spurious flag");

        wr(12'h048, 32'h1);
        rd(12'h040, 32'd40, "R8 winner 40 after ack");
        src_lvl[40] = 1'b0;
        idle(1);
        wr(12'h048, 32'h1);
        check_irq(1'b0, "R8 irq drops when nothing pending");

        // R10 threshold
        wr(12'h068, 32'h0);
        rd(12'h068, 32'h0, "R10 threshold readback");
        src_lvl[41] = 1'b1;
        idle(3);
        check_irq(1'b0, "R10 threshold 0 blocks");
        wr(12'h068, 32'h0000_00FF);
        idle(2);
        check_irq(1'b1, "R10 threshold FF passes");
        rd(12'h040, 32'd41, "R10 winner 41");

        // R12 unmapped write ignored
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, 32'h0, "R12 unmapped write ignored");
        rd(12'h0AC, 32'hFFFF_FCFF, "R12 mask untouched");

        // R9 soft reset
        wr(12'h010, 32'h2);
        rd(12'h014, 32'h0, "R9 status busy");
        idle(8);
        rd(12'h014, 32'h1, "R9 status done");
        rd(12'h0AC, 32'hFFFF_FFFF, "R9 masks restored");
        rd(12'h068, 32'h0000_00FF, "R9 threshold restored");
        check_irq(1'b0, "R9 irq low after soft reset");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule